// File: doc/BRIEF.md
# Program Sequencer with Circular Return Stack

This block produces the 13-bit fetch address of a small accumulator-style processor. Each instruction cycle lasts a fixed number of clocks (four by default); at the last clock of the cycle the sequencer takes the control class of the instruction now executing and moves the program counter. The class can be plain sequential, jump, call, return, return with literal, or return from interrupt. An ALU skip request is also taken into account. Jump and call targets put an 11-bit immediate in the low bits and take the two upper bits from bits 4:3 of a separate page latch.

Any taken transfer, and any true skip, marks the instruction already fetched as a bubble. In the following cycle that slot runs as a no-operation and the sequencer ignores its inputs, so the transfer costs exactly two instruction cycles. Return addresses go into an 8-entry circular stack. When an interrupt is accepted, the sequencer pushes the fetch address, clears the global enable and vectors to address 0x004. All pins are plain control and status. The block has no streamed data interface, so no valid/ready handshake and no back-pressure apply.

Top module: `prog_seq`

## Requirements
- R1: While reset is asserted and right after it, pc is 0x0000, flush is 0 and gie is 0. The stack pointer is cleared and all stack entries hold zero.
- R2: One instruction cycle lasts PHASES clocks. cyc_tick is high only on the last of them. pc, flush and gie change only at the clock edge that ends a cycle with cyc_tick high.
- R3: op_cls encodes 0 = sequential, 1 = jump, 2 = call, 3 = return, 4 = return with literal, 5 = return from interrupt; 6 and 7 act as sequential. A sequential cycle with no skip and no accepted interrupt advances pc by one, wrapping from 0x1FFF to 0x0000.
- R4: A jump loads pc with {latch[4:3], imm[10:0]} and sets flush.
- R5: A call pushes the current pc, which is the address after the call, and then loads the same target as a jump, setting flush.
- R6: A return pops the top of stack into pc and sets flush. A return with literal does the same and also raises w_load during its cycle-ending clock, with w_lit = imm[7:0].
- R7: A return from interrupt pops into pc, sets flush and gie, and raises gie_set during its cycle-ending clock.
- R8: A sequential cycle with skip_req = 1 advances pc by one and sets flush.
- R9: In a cycle that begins with flush = 1, op_cls, skip_req and irq are ignored. pc advances by one, flush returns to 0 and gie is unchanged.
- R10: irq is accepted only in a sequential cycle with flush = 0, skip_req = 0 and gie = 1. Acceptance pushes pc, loads 0x004, clears gie and sets flush. In any other cycle the request is not taken.
- R11: The stack holds 8 entries and is circular. A ninth push overwrites the oldest entry, and a pop from an empty stack wraps to the last slot. No flag is raised for either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_cls | input | 3 | Control class of the executing instruction |
| imm | input | 11 | Immediate field; bits 7:0 are the return literal |
| latch | input | 5 | Page latch; bits 4:3 form target bits 12:11 |
| skip_req | input | 1 | ALU reports a true skip condition |
| irq | input | 1 | Interrupt request |
| pc | output | 13 | Current fetch address |
| flush | output | 1 | The executing slot is a bubble (no-operation) |
| gie | output | 1 | Global interrupt enable state |
| cyc_tick | output | 1 | Last clock of the instruction cycle |
| w_load | output | 1 | Load W with w_lit (return with literal) |
| w_lit | output | 8 | Literal for W |
| gie_set | output | 1 | Strobe: return from interrupt sets the enable |

## Verification
The assertions watch several rules on every clock. State holds still between cycle ends. A bubble slot always advances by one and clears itself. Jump targets are assembled from the latch page bits. An accepted interrupt lands on the vector with the enable cleared. A literal load never comes from a bubble, and the enable is set after its strobe. Stack contents are a different matter. The order of return addresses, an overwrite on the ninth push, a wrap when an empty stack is popped, and the deferral of an interrupt during a transfer can only be shown by the bench's scenarios and its per-clock reference model.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  localparam logic [2:0] CLS_NEXT   = 3'd0;
  localparam logic [2:0] CLS_JUMP   = 3'd1;
  localparam logic [2:0] CLS_CALL   = 3'd2;
  localparam logic [2:0] CLS_RET    = 3'd3;
  localparam logic [2:0] CLS_RETLIT = 3'd4;
  localparam logic [2:0] CLS_RETINT = 3'd5;
endpackage

// File: rtl/seq_phase.sv
module seq_phase #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;

  generate
    if (PHASES == 1) begin : g_single
      assign tick = 1'b1;
    end else begin : g_count
      logic [PH_W-1:0] ph_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ph_q <= '0;
        else if (ph_q == PH_W'(PHASES - 1)) ph_q <= '0;
        else                                ph_q <= ph_q + PH_W'(1);
      end
      assign tick = (ph_q == PH_W'(PHASES - 1));
    end
  endgenerate
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] tos
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp_q] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_q <= '0;
    else if (push) sp_q <= sp_q + AW'(1);
    else if (pop)  sp_q <= sp_q - AW'(1);
  end

  assign tos = mem[sp_q - AW'(1)];
endmodule

// File: rtl/seq_next.sv
module seq_next
  import prog_seq_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int IMM_W   = 11,
  parameter int LATCH_W = 5,
  parameter int PG_LSB  = 3,
  parameter int VEC     = 4
) (
  input  logic [PC_W-1:0]    pc_q,
  input  logic               flush_q,
  input  logic               gie_q,
  input  logic [2:0]         cls,
  input  logic [IMM_W-1:0]   imm,
  input  logic [LATCH_W-1:0] latch,
  input  logic               skip_req,
  input  logic               irq,
  input  logic [PC_W-1:0]    tos,
  output logic [PC_W-1:0]    pc_nxt,
  output logic               flush_nxt,
  output logic               gie_nxt,
  output logic               push,
  output logic               pop,
  output logic               wl_raw,
  output logic               gs_raw
);
  localparam int PG_W = PC_W - IMM_W;

  logic [PC_W-1:0] target;
  assign target = {latch[PG_LSB +: PG_W], imm};

  always_comb begin
    pc_nxt    = pc_q + PC_W'(1);
    flush_nxt = 1'b0;
    gie_nxt   = gie_q;
    push      = 1'b0;
    pop       = 1'b0;
    wl_raw    = 1'b0;
    gs_raw    = 1'b0;
    if (!flush_q) begin
      case (cls)
        CLS_JUMP: begin
          pc_nxt    = target;
          flush_nxt = 1'b1;
        end
        CLS_CALL: begin
          push      = 1'b1;
          pc_nxt    = target;
          flush_nxt = 1'b1;
        end
        CLS_RET, CLS_RETLIT, CLS_RETINT: begin
          pop       = 1'b1;
          pc_nxt    = tos;
          flush_nxt = 1'b1;
          wl_raw    = (cls == CLS_RETLIT);
          gs_raw    = (cls == CLS_RETINT);
          if (cls == CLS_RETINT) gie_nxt = 1'b1;
        end
        default: begin
          if (skip_req) begin
            flush_nxt = 1'b1;
          end else if (irq && gie_q) begin
            push      = 1'b1;
            pc_nxt    = PC_W'(VEC);
            gie_nxt   = 1'b0;
            flush_nxt = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int PHASES  = 4,
  parameter int PC_W    = 13,
  parameter int IMM_W   = 11,
  parameter int LATCH_W = 5,
  parameter int DEPTH   = 8,
  parameter int VEC     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_cls,
  input  logic [IMM_W-1:0]   imm,
  input  logic [LATCH_W-1:0] latch,
  input  logic               skip_req,
  input  logic               irq,
  output logic [PC_W-1:0]    pc,
  output logic               flush,
  output logic               gie,
  output logic               cyc_tick,
  output logic               w_load,
  output logic [7:0]         w_lit,
  output logic               gie_set
);
  logic [PC_W-1:0] pc_q, pc_nxt, tos;
  logic            flush_q, flush_nxt, gie_q, gie_nxt;
  logic            push, pop, wl_raw, gs_raw, tick;

  seq_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  seq_next #(
    .PC_W(PC_W), .IMM_W(IMM_W), .LATCH_W(LATCH_W), .PG_LSB(3), .VEC(VEC)
  ) u_next (
    .pc_q(pc_q), .flush_q(flush_q), .gie_q(gie_q), .cls(op_cls),
    .imm(imm), .latch(latch), .skip_req(skip_req), .irq(irq), .tos(tos),
    .pc_nxt(pc_nxt), .flush_nxt(flush_nxt), .gie_nxt(gie_nxt),
    .push(push), .pop(pop), .wl_raw(wl_raw), .gs_raw(gs_raw)
  );

  seq_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push & tick), .pop(pop & tick),
    .din(pc_q), .tos(tos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
      gie_q   <= 1'b0;
    end else if (tick) begin
      pc_q    <= pc_nxt;
      flush_q <= flush_nxt;
      gie_q   <= gie_nxt;
    end
  end

  assign pc       = pc_q;
  assign flush    = flush_q;
  assign gie      = gie_q;
  assign cyc_tick = tick;
  assign w_load   = tick & wl_raw;
  assign w_lit    = imm[7:0];
  assign gie_set  = tick & gs_raw;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int PC_W    = 13,
  parameter int IMM_W   = 11,
  parameter int LATCH_W = 5,
  parameter int VEC     = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         op_cls,
  input logic [IMM_W-1:0]   imm,
  input logic [LATCH_W-1:0] latch,
  input logic               skip_req,
  input logic               irq,
  input logic [PC_W-1:0]    pc,
  input logic               flush,
  input logic               gie,
  input logic               cyc_tick,
  input logic               w_load,
  input logic               gie_set
);
  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick |=> ($stable(pc) && $stable(flush) && $stable(gie)));

  // R9
  bubble_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && flush) |=> (pc == PC_W'($past(pc) + PC_W'(1))) && !flush && $stable(gie));

  // R4
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && !flush && op_cls == 3'd1) |=>
      (pc == {$past(latch[4:3]), $past(imm)}) && flush);

  // R10
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_tick && !flush && gie && irq && !skip_req && (op_cls == 3'd0 || op_cls > 3'd5))
      |=> (pc == PC_W'(VEC)) && !gie && flush);

  // R6
  wload_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |-> (cyc_tick && !flush));

  // R7
  gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set |=> (gie && flush));
endmodule

bind prog_seq prog_seq_chk #(
  .PC_W(PC_W), .IMM_W(IMM_W), .LATCH_W(LATCH_W), .VEC(VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .imm(imm), .latch(latch),
  .skip_req(skip_req), .irq(irq), .pc(pc), .flush(flush), .gie(gie),
  .cyc_tick(cyc_tick), .w_load(w_load), .gie_set(gie_set)
);

// File: tb/tb_prog_seq.sv
module tb_prog_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_cls = 3'd0;
  logic [10:0] imm = '0;
  logic [4:0]  latch = '0;
  logic        skip_req = 1'b0;
  logic        irq = 1'b0;
  logic [12:0] pc;
  logic        flush, gie, cyc_tick, w_load, gie_set;
  logic [7:0]  w_lit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_ph, m_pc, m_sp;
  bit m_fl, m_gie;
  int m_stk[8];

  // strobes captured at the cycle-ending clock
  bit t_wl, t_gs;
  int t_lit;

  always #5 clk = ~clk;

  prog_seq dut (
    .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .imm(imm), .latch(latch),
    .skip_req(skip_req), .irq(irq), .pc(pc), .flush(flush), .gie(gie),
    .cyc_tick(cyc_tick), .w_load(w_load), .w_lit(w_lit), .gie_set(gie_set)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit seq_like(input int c);
    return (c == 0 || c > 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_sp = 0; m_fl = 0; m_gie = 0;
      for (int i = 0; i < 8; i++) m_stk[i] = 0;
    end else begin
      if (m_ph == 3) begin
        int c;
        int tgt;
        c = int'(op_cls);
        tgt = (int'(latch[4:3]) << 11) | int'(imm);
        if (m_fl) begin
          m_pc = (m_pc + 1) % 8192; m_fl = 0;
        end else if (c == 1) begin
          m_pc = tgt; m_fl = 1;
        end else if (c == 2) begin
          m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = tgt; m_fl = 1;
        end else if (c >= 3 && c <= 5) begin
          m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; m_fl = 1;
          if (c == 5) m_gie = 1;
        end else if (skip_req) begin
          m_pc = (m_pc + 1) % 8192; m_fl = 1;
        end else if (irq && m_gie) begin
          m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = 4; m_gie = 0; m_fl = 1;
        end else begin
          m_pc = (m_pc + 1) % 8192;
        end
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit etick;
      etick = (m_ph == 3);
      chk("R3 pc", int'(pc), m_pc);
      chk("R8 flush", int'(flush), int'(m_fl));
      chk("R10 gie", int'(gie), int'(m_gie));
      chk("R2 cyc_tick", int'(cyc_tick), int'(etick));
      chk("R6 w_load", int'(w_load), int'(etick && !m_fl && op_cls == 3'd4));
      chk("R7 gie_set", int'(gie_set), int'(etick && !m_fl && op_cls == 3'd5));
      if (w_load) chk("R6 w_lit", int'(w_lit), int'(imm[7:0]));
    end
  end

  task automatic instr(input int c, input int k, input int lt, input bit sk, input bit rq);
    op_cls = 3'(c); imm = 11'(k); latch = 5'(lt); skip_req = sk; irq = rq;
    repeat (3) @(negedge clk);
    t_wl = w_load; t_gs = gie_set; t_lit = int'(w_lit);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v[9];
    int unsigned r;
    repeat (3) @(negedge clk);
    // R1 reset values while reset is held
    chk("R1 pc in reset", int'(pc), 0);
    chk("R1 gie in reset", int'(gie), 0);
    rst_n = 1'b1;
    chk("R1 pc", int'(pc), 0);
    chk("R1 flush", int'(flush), 0);
    chk("R1 gie", int'(gie), 0);

    // R3 sequential
    instr(0, 0, 0, 0, 0); instr(6, 0, 0, 0, 0); instr(0, 0, 0, 0, 0);
    chk("R3 seq count", int'(pc), 3);
    // R4 jump with page bits from latch[4:3]
    instr(1, 'h123, 'b10000, 0, 0);
    chk("R4 jump pc", int'(pc), 'h1123);
    chk("R4 jump flush", int'(flush), 1);
    // R9 bubble ignores a call
    instr(2, 'h7FF, 'b11000, 1, 1);
    chk("R9 bubble pc", int'(pc), 'h1124);
    chk("R9 bubble flush", int'(flush), 0);
    // R5 call
    instr(2, 'h050, 0, 0, 0);
    chk("R5 call pc", int'(pc), 'h050);
    instr(0, 0, 0, 0, 0); instr(0, 0, 0, 0, 0);
    // R6 return with literal
    instr(4, 'h3A7, 0, 0, 0);
    chk("R6 ret pc", int'(pc), 'h1124);
    chk("R6 w_load strobe", int'(t_wl), 1);
    chk("R6 literal", t_lit, 'hA7);
    instr(0, 0, 0, 0, 0);
    // R8 skip, then bubble with skip asserted again
    instr(0, 0, 0, 1, 0);
    chk("R8 skip pc", int'(pc), 'h1126);
    chk("R8 skip flush", int'(flush), 1);
    instr(0, 0, 0, 1, 0);
    chk("R9 skip in bubble", int'(flush), 0);
    // R7 + R11: return from interrupt on empty stack wraps to slot 7 (zero)
    instr(5, 0, 0, 0, 0);
    chk("R11 empty pop pc", int'(pc), 0);
    chk("R7 gie", int'(gie), 1);
    chk("R7 gie_set strobe", int'(t_gs), 1);
    instr(0, 0, 0, 0, 0);
    // R10 accept
    instr(0, 0, 0, 0, 1);
    chk("R10 vector", int'(pc), 4);
    chk("R10 gie cleared", int'(gie), 0);
    instr(0, 0, 0, 0, 1);
    instr(0, 0, 0, 0, 1);
    chk("R10 not taken when disabled", int'(pc), 6);
    instr(5, 0, 0, 0, 0);
    chk("R10 return addr", int'(pc), 1);
    instr(0, 0, 0, 0, 0);
    // R10 deferred during a jump
    instr(1, 'h200, 0, 0, 1);
    chk("R10 deferred on jump", int'(pc), 'h200);
    chk("R10 gie kept", int'(gie), 1);
    instr(0, 0, 0, 0, 1);
    chk("R9 irq in bubble", int'(pc), 'h201);
    instr(0, 0, 0, 0, 1);
    chk("R10 second accept", int'(pc), 4);
    instr(0, 0, 0, 0, 0);
    // R3 wrap
    instr(1, 'h7FF, 'b11000, 0, 0);
    chk("R3 top addr", int'(pc), 'h1FFF);
    instr(0, 0, 0, 0, 0);
    chk("R3 wrap", int'(pc), 0);
    // R11 nine nested calls
    for (int k = 0; k < 9; k++) begin
      v[k] = int'(pc);
      instr(2, 'h100 + k * 16, 0, 0, 0);
      instr(0, 0, 0, 0, 0);
    end
    for (int k = 8; k >= 1; k--) begin
      instr(3, 0, 0, 0, 0);
      chk("R11 pop order", int'(pc), v[k]);
      instr(0, 0, 0, 0, 0);
    end
    instr(3, 0, 0, 0, 0);
    chk("R11 overwrite oldest", int'(pc), v[8]);
    instr(0, 0, 0, 0, 0);
    // mixed traffic, checked by the model every clock
    r = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      instr(int'(r % 8), int'((r >> 3) & 'h7FF), int'((r >> 14) & 'h1F),
            r[20] & r[21], r[22]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule